// File: doc/BRIEF.md
# GPIO Bank Interrupt Controller

This block serves one bank of 32 general-purpose pins. Software reaches it through a simple single-cycle register bus. Each pin has six control bits: an output value, a direction, an interrupt enable, an interrupt mask, a trigger kind and a polarity. Every control register is split into two halfword registers. Pins 0 to 15 sit at a base offset and pins 16 to 31 sit four bytes higher. Each write carries its own per-bit write enables in the upper halfword, so one pin can be changed without a read-modify-write.

The pin inputs pass through a two-flop synchronizer. A third flop keeps the previous level so that edges can be found. A level condition drives a pin's raw bit directly. An edge event sets a sticky bit, and that bit stays set until software clears it through the end-of-interrupt register. The masked status is the raw bit, qualified by the enable bit and by the inverted mask bit. The interrupt output is the OR of all status bits.

Top module: `gpio_irq_bank`

## Requirements
- R1: For a write to any control halfword, wdata[31:16] is a per-bit write enable for wdata[15:0]. A bit whose enable is 0 keeps its value. All control bits reset to 0.
- R2: Pins 0-15 of a control register are at its base offset and pins 16-31 are at base+4. The offsets are: output value 0x00, direction 0x08, enable 0x10, mask 0x18, trigger kind 0x20, polarity 0x28, end-of-interrupt 0x60. Reads of a control halfword return 0 in bits [31:16].
- R3: pin_out mirrors the output-value bits. pin_oe mirrors the direction bits, where 1 means the pin is an output.
- R4: With trigger kind 0 (level), a pin's raw bit is 1 while the synchronized pin equals its polarity bit. The raw bit is not latched. After reset all pins are level-low inputs, so with the pins low the raw status at 0x58 reads 0xFFFFFFFF.
- R5: With trigger kind 1 (edge), polarity 1 latches a rising edge and polarity 0 latches a falling edge into a sticky raw bit. The opposite edge does not set it.
- R6: Writing 1 to a pin's end-of-interrupt bit with its enable set clears the latched edge. A 0 data bit, or a 0 enable bit, has no effect. An edge that arrives in the same cycle as its clear leaves the bit set.
- R7: Status at 0x50 is raw AND enable AND NOT mask. irq is the OR of all status bits.
- R8: Writing 0xFFFF0000 to both enable halves (0x10 and 0x14) disables every pin, and irq falls.
- R9: The register at 0x70 returns all 32 synchronized pin levels. Writes to 0x50, 0x58 and 0x70 change nothing.
- R10: A pin whose direction bit is 1 never sets its raw bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data, with write enables in the upper half |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_in | input | 32 | Pin levels from the pads, asynchronous |
| pin_out | output | 32 | Output values to the pads |
| pin_oe | output | 32 | Output enables to the pads |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume the following about the inputs:
- A bus access lasts a single cycle.
- The address is word aligned.
- pin_in changes only between clock edges, so that the synchronizer sees clean levels.

The stimulus drives every bus field and pin at the falling clock edge and drops bus_sel after one rising edge. It holds pins steady long enough for the sticky-edge property to compare the raw state before and after a clock.

The same-cycle clear case is timed to land exactly two rising edges after a pin change. This is the cycle in which the edge detector fires.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pin_in,
  output logic [31:0] pin_out,
  output logic [31:0] pin_oe,
  output logic        irq
);
  logic [31:0] dout, dir, en, msk, typ, pol;
  logic [31:0] s1, s2, s3, lat;
  logic [31:0] ev, lvl, raw, status, eoi_clr;
  logic        wr;

  function automatic logic [15:0] mwr(input logic [15:0] old, input logic [31:0] wd);
    return (old & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
  endfunction

  assign wr = bus_sel & bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0; dir <= '0; en <= '0; msk <= '0; typ <= '0; pol <= '0;
    end else if (wr) begin
      case (bus_addr)
        8'h00: dout[15:0]  <= mwr(dout[15:0],  bus_wdata);
        8'h04: dout[31:16] <= mwr(dout[31:16], bus_wdata);
        8'h08: dir[15:0]   <= mwr(dir[15:0],   bus_wdata);
        8'h0C: dir[31:16]  <= mwr(dir[31:16],  bus_wdata);
        8'h10: en[15:0]    <= mwr(en[15:0],    bus_wdata);
        8'h14: en[31:16]   <= mwr(en[31:16],   bus_wdata);
        8'h18: msk[15:0]   <= mwr(msk[15:0],   bus_wdata);
        8'h1C: msk[31:16]  <= mwr(msk[31:16],  bus_wdata);
        8'h20: typ[15:0]   <= mwr(typ[15:0],   bus_wdata);
        8'h24: typ[31:16]  <= mwr(typ[31:16],  bus_wdata);
        8'h28: pol[15:0]   <= mwr(pol[15:0],   bus_wdata);
        8'h2C: pol[31:16]  <= mwr(pol[31:16],  bus_wdata);
        default: ;
      endcase
    end
  end

  assign eoi_clr[15:0]  = (wr && bus_addr == 8'h60) ? (bus_wdata[15:0] & bus_wdata[31:16]) : 16'h0;
  assign eoi_clr[31:16] = (wr && bus_addr == 8'h64) ? (bus_wdata[15:0] & bus_wdata[31:16]) : 16'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; lat <= '0;
    end else begin
      s1  <= pin_in;
      s2  <= s1;
      s3  <= s2;
      lat <= typ & ~dir & ((lat & ~eoi_clr) | ev);
    end
  end

  assign ev     = typ & ~dir & ((pol & s2 & ~s3) | (~pol & ~s2 & s3));
  assign lvl    = ~typ & ~dir & ~(s2 ^ pol);
  assign raw    = (typ & ~dir & lat) | lvl;
  assign status = raw & en & ~msk;
  assign irq    = |status;

  assign pin_out = dout;
  assign pin_oe  = dir;

  always_comb begin
    case (bus_addr)
      8'h00: bus_rdata = {16'h0, dout[15:0]};
      8'h04: bus_rdata = {16'h0, dout[31:16]};
      8'h08: bus_rdata = {16'h0, dir[15:0]};
      8'h0C: bus_rdata = {16'h0, dir[31:16]};
      8'h10: bus_rdata = {16'h0, en[15:0]};
      8'h14: bus_rdata = {16'h0, en[31:16]};
      8'h18: bus_rdata = {16'h0, msk[15:0]};
      8'h1C: bus_rdata = {16'h0, msk[31:16]};
      8'h20: bus_rdata = {16'h0, typ[15:0]};
      8'h24: bus_rdata = {16'h0, typ[31:16]};
      8'h28: bus_rdata = {16'h0, pol[15:0]};
      8'h2C: bus_rdata = {16'h0, pol[31:16]};
      8'h50: bus_rdata = status;
      8'h58: bus_rdata = raw;
      8'h70: bus_rdata = s2;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        irq,
  input logic [31:0] raw,
  input logic [31:0] en,
  input logic [31:0] msk,
  input logic [31:0] typ,
  input logic [31:0] dir,
  input logic [31:0] dout,
  input logic [31:0] eoi_clr
);
  p_irq_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(raw & en & ~msk));

  p_output_pin_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (raw & dir) == 32'h0);

  p_ro_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (bus_addr == 8'h50 || bus_addr == 8'h58 || bus_addr == 8'h70))
    |=> ($stable(en) && $stable(msk) && $stable(dir) && $stable(dout) && $stable(typ)));

  p_disable_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 8'h10 && bus_wdata == 32'hFFFF0000) |=> en[15:0] == 16'h0);

  p_upper_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr < 8'h30) |-> bus_rdata[31:16] == 16'h0);

  p_edge_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(raw) & $past(typ) & ~$past(dir) & ~$past(eoi_clr)) & typ & ~dir & ~raw) == 32'h0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .raw(raw), .en(en),
  .msk(msk), .typ(typ), .dir(dir), .dout(dout), .eoi_clr(eoi_clr)
);

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_bank u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 reset irq", {31'h0, irq}, 32'h0);
    rd(8'h08, d); chk("R1 reset direction", d, 32'h0);
    rd(8'h50, d); chk("R7 reset status", d, 32'h0);
    rd(8'h58, d); chk("R4 reset raw level-low", d, 32'hFFFFFFFF);
  endtask

  task automatic t_masked_write();
    logic [31:0] d;
    wr(8'h08, 32'h00FF00FF);
    rd(8'h08, d); chk("R1 enabled bits written", d, 32'h000000FF);
    wr(8'h08, 32'h00F00000);
    rd(8'h08, d); chk("R1 unenabled bits kept", d, 32'h0000000F);
    wr(8'h0C, 32'hFFFF8001);
    rd(8'h0C, d); chk("R2 upper half read", d, 32'h00008001);
    chk("R3 pin_oe", pin_oe, 32'h8001000F);
    wr(8'h00, 32'hFFFFA5A5);
    wr(8'h04, 32'h00FF0034);
    chk("R3 pin_out", pin_out, 32'h0034A5A5);
    wr(8'h08, 32'hFFFF0000);
    wr(8'h0C, 32'hFFFF0000);
    chk("R3 pin_oe cleared", pin_oe, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(8'h28, 32'h00200020);
    wr(8'h10, 32'h00200020);
    wait_clk(3);
    chk("R4 level-high idle", {31'h0, irq}, 32'h0);
    pin_in[5] = 1'b1; wait_clk(3);
    chk("R4 level-high active irq", {31'h0, irq}, 32'h1);
    rd(8'h50, d); chk("R7 status bit5", d, 32'h00000020);
    pin_in[5] = 1'b0; wait_clk(3);
    chk("R4 level not latched", {31'h0, irq}, 32'h0);
    pin_in[5] = 1'b1; wait_clk(3);
    wr(8'h18, 32'h00200020);
    chk("R7 masked irq", {31'h0, irq}, 32'h0);
    rd(8'h58, d); chk("R7 raw under mask", d & 32'h20, 32'h20);
    wr(8'h18, 32'h00200000);
    wr(8'h10, 32'h00200000);
    pin_in[5] = 1'b0; wait_clk(3);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(8'h24, 32'h00100010);
    wr(8'h2C, 32'h00100010);
    wr(8'h14, 32'h00100010);
    wait_clk(3);
    rd(8'h58, d); chk("R5 edge idle", d & 32'h00100000, 32'h0);
    pin_in[20] = 1'b1; wait_clk(4);
    rd(8'h50, d); chk("R5 rising latched", d, 32'h00100000);
    pin_in[20] = 1'b0; wait_clk(4);
    chk("R5 sticky after pin low", {31'h0, irq}, 32'h1);
    wr(8'h64, 32'h00100000);
    chk("R6 eoi data 0 ignored", {31'h0, irq}, 32'h1);
    wr(8'h64, 32'h00000010);
    chk("R6 eoi without enable ignored", {31'h0, irq}, 32'h1);
    wr(8'h64, 32'h00100010);
    chk("R6 eoi clears", {31'h0, irq}, 32'h0);
    wr(8'h2C, 32'h00100000);
    pin_in[20] = 1'b1; wait_clk(4);
    rd(8'h58, d); chk("R5 falling mode ignores rise", d & 32'h00100000, 32'h0);
    pin_in[20] = 1'b0; wait_clk(4);
    rd(8'h58, d); chk("R5 falling latched", d & 32'h00100000, 32'h00100000);
    wr(8'h64, 32'h00100010);
    wr(8'h2C, 32'h00100010);
    wait_clk(2);
  endtask

  task automatic t_eoi_collide();
    logic [31:0] d;
    @(negedge clk);
    pin_in[20] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h64; bus_wdata = 32'h00100010;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    rd(8'h58, d); chk("R6 edge beats same-cycle clear", d & 32'h00100000, 32'h00100000);
    wr(8'h64, 32'h00100010);
    rd(8'h58, d); chk("R6 later clear", d & 32'h00100000, 32'h0);
  endtask

  task automatic t_output_pin();
    logic [31:0] d;
    wr(8'h0C, 32'h00100010);
    pin_in[20] = 1'b0; wait_clk(4);
    pin_in[20] = 1'b1; wait_clk(4);
    rd(8'h58, d); chk("R10 output pin no raw", d & 32'h00100000, 32'h0);
    chk("R10 output pin no irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    pin_in = 32'hDEADBEEF; wait_clk(3);
    rd(8'h70, d); chk("R9 pin level read", d, 32'hDEADBEEF);
    wr(8'h70, 32'hFFFFFFFF);
    wr(8'h50, 32'hFFFFFFFF);
    wr(8'h58, 32'hFFFFFFFF);
    rd(8'h14, d); chk("R9 enable untouched", d, 32'h00000010);
    rd(8'h0C, d); chk("R9 direction untouched", d, 32'h00000010);
    rd(8'h70, d); chk("R9 pin level unchanged", d, 32'hDEADBEEF);
    pin_in = 32'h0; wait_clk(4);
  endtask

  task automatic t_disable_all();
    logic [31:0] d;
    wr(8'h10, 32'hFFFFFFFF);
    wr(8'h14, 32'hFFFFFFFF);
    chk("R8 irq before disable", {31'h0, irq}, 32'h1);
    wr(8'h10, 32'hFFFF0000);
    wr(8'h14, 32'hFFFF0000);
    chk("R8 irq after disable", {31'h0, irq}, 32'h0);
    rd(8'h10, d); chk("R8 low enables", d, 32'h0);
    rd(8'h14, d); chk("R8 high enables", d, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    wait_clk(3);
    t_reset();
    t_masked_write();
    t_level();
    t_edge();
    t_eoi_collide();
    t_output_pin();
    t_readonly();
    t_disable_all();
    report();
  end
endmodule